// File: doc/BRIEF.md
# Floating-point exponent/mantissa decomposition unit

This unit splits a single-precision IEEE-754 operand, viewed as m * 2^e with m in [1, 2) and e the unbiased exponent, into the pieces that the argument-reduction step of a reciprocal, square-root or reciprocal-square-root sequence needs. A 3-bit operation select chooses one of five results. Two of them are range-reduced mantissas, returned as floats. The other three are derived exponents, returned as signed 32-bit integers.

The mantissa results keep the operand's sign. They move the significand into a fixed window: [0.5, 1) for the reciprocal form. For the square-root form the window is [0.25, 1), reached by scaling with a power of four chosen by the parity of e. The exponent results apply closed integer formulas in e. Floor is always taken toward negative infinity. Denormal operands are first normalized with a leading-zero count. Zero, infinity and NaN have fixed results. The datapath is combinational, and a parameter can add one output register stage.

Top module: `fpd_unit`

## Requirements
- R1: Select code 0 returns m * 2^-1 as a float: the operand's sign bit, exponent field 126, and the fraction bits of the normalized significand.
- R2: Select code 1 returns a float with the operand's sign and the normalized fraction. Its exponent field is 125 (m * 2^-2) when e is even and 126 (m * 2^-1) when e is odd, so the magnitude lies in [0.25, 1).
- R3: Select code 2 returns -e - 1 as a 32-bit two's-complement integer.
- R4: Select code 3 returns floor(e/2) + 1 as a 32-bit two's-complement integer, with floor toward negative infinity.
- R5: Select code 4 returns -floor(e/2) - 1 as a 32-bit two's-complement integer.
- R6: A denormal operand (exponent field 0, fraction nonzero) is treated as having e = -127 - z, where z is the count of leading zeros in the 23-bit fraction. Its significand fraction is the fraction shifted left by z + 1.
- R7: For zero, infinity or NaN operands, codes 0 and 1 return the operand bits unchanged.
- R8: For zero, infinity or NaN operands, codes 2, 3 and 4 return 0.
- R9: Codes 5, 6 and 7 return 0 for every operand.
- R10: With OUT_REG = 1 the result appears one clock edge after the inputs, and reset forces the result to 0. With OUT_REG = 0 the result follows the inputs without a clock and ignores reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_sel | input | 3 | Operation select (codes 0 to 4 defined) |
| operand | input | 32 | Single-precision operand |
| result | output | 32 | Float mantissa or signed integer exponent |

## Verification
The bench builds two copies side by side: `uut` with OUT_REG = 0 and a second copy with OUT_REG = 1. Every vector is checked on the unclocked path and then, one edge later, on the registered path. The registered copy makes reset clearing and the one-cycle latency observable. The unclocked copy shows that reset has no effect without the register. The vectors cover even and odd, positive and negative exponents, so the floor and parity cases are exercised. They also reach the exponent extremes, several denormal leading-zero depths, and every special class.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int WORD_W = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int LZ_W   = $clog2(FRAC_W + 1);
    localparam int EU_W   = EXP_W + 2;

    localparam logic [EXP_W-1:0] EXP_HALF    = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] EXP_QUARTER = EXP_W'(BIAS - 2);
    localparam logic [EXP_W-1:0] EXP_ONES    = '1;

    typedef enum logic [2:0] {
        OP_RCP_MANT  = 3'd0,
        OP_SQRT_MANT = 3'd1,
        OP_RCP_EXP   = 3'd2,
        OP_SQRT_EXP  = 3'd3,
        OP_RSQ_EXP   = 3'd4
    } fpd_op_e;

    typedef struct packed {
        logic                   sign;
        logic                   is_zero;
        logic                   is_inf;
        logic                   is_nan;
        logic signed [EU_W-1:0] exp_unb;
        logic [FRAC_W-1:0]      frac_norm;
    } fpd_split_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FRAC_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (v[i]) hit = 1'b1;
            else if (!hit) n = n + 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/fpd_unpack.sv
module fpd_unpack
    import fpd_pkg::*;
(
    input  logic [WORD_W-1:0] operand,
    output fpd_split_t        split
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic [LZ_W-1:0]   lz;

    assign exp_f  = operand[WORD_W-2 -: EXP_W];
    assign frac_f = operand[FRAC_W-1:0];
    assign lz     = lead_zeros(frac_f);

    always_comb begin
        split.sign    = operand[WORD_W-1];
        split.is_zero = (exp_f == '0) && (frac_f == '0);
        split.is_inf  = (exp_f == EXP_ONES) && (frac_f == '0);
        split.is_nan  = (exp_f == EXP_ONES) && (frac_f != '0);
        if (exp_f == '0) begin
            // denormal: leading one sits lz places below the top fraction bit
            split.exp_unb   = -EU_W'(BIAS) - $signed({{(EU_W-LZ_W){1'b0}}, lz});
            split.frac_norm = frac_f << (lz + 1'b1);
        end else begin
            split.exp_unb   = $signed({2'b00, exp_f}) - EU_W'(BIAS);
            split.frac_norm = frac_f;
        end
    end
endmodule

// File: rtl/fpd_mant.sv
module fpd_mant
    import fpd_pkg::*;
(
    input  logic [2:0]        op_sel,
    input  logic [WORD_W-1:0] operand,
    input  fpd_split_t        split,
    output logic [WORD_W-1:0] mant_res
);
    logic             special;
    logic [EXP_W-1:0] exp_out;
    logic             unused_exp_hi;

    assign special       = split.is_zero | split.is_inf | split.is_nan;
    assign unused_exp_hi = ^split.exp_unb[EU_W-1:1];

    always_comb begin
        // even exponent under the square-root form takes one extra halving
        if (op_sel == OP_SQRT_MANT && !split.exp_unb[0]) exp_out = EXP_QUARTER;
        else exp_out = EXP_HALF;
        if (special) mant_res = operand;
        else mant_res = {split.sign, exp_out, split.frac_norm};
    end
endmodule

// File: rtl/fpd_expo.sv
module fpd_expo
    import fpd_pkg::*;
(
    input  logic [2:0]        op_sel,
    input  fpd_split_t        split,
    output logic [WORD_W-1:0] exp_res
);
    logic signed [EU_W-1:0] half_e;
    logic signed [EU_W-1:0] val;
    logic                   special;
    logic                   unused_bits;

    assign special     = split.is_zero | split.is_inf | split.is_nan;
    assign half_e      = split.exp_unb >>> 1;
    assign unused_bits = ^{split.sign, split.frac_norm};

    always_comb begin
        // -x - 1 equals the bitwise complement of x in two's complement
        case (op_sel)
            OP_RCP_EXP:  val = ~split.exp_unb;
            OP_SQRT_EXP: val = half_e + EU_W'(1);
            OP_RSQ_EXP:  val = ~half_e;
            default:     val = '0;
        endcase
        if (special) exp_res = '0;
        else exp_res = {{(WORD_W-EU_W){val[EU_W-1]}}, val};
    end
endmodule

// File: rtl/fpd_unit.sv
module fpd_unit
    import fpd_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_sel,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] result
);
    fpd_split_t        split;
    logic [WORD_W-1:0] mant_res;
    logic [WORD_W-1:0] exp_res;
    logic [WORD_W-1:0] res_next;

    fpd_unpack u_unpack (.operand(operand), .split(split));
    fpd_mant   u_mant   (.op_sel(op_sel), .operand(operand), .split(split), .mant_res(mant_res));
    fpd_expo   u_expo   (.op_sel(op_sel), .split(split), .exp_res(exp_res));

    always_comb begin
        case (op_sel)
            OP_RCP_MANT, OP_SQRT_MANT:            res_next = mant_res;
            OP_RCP_EXP, OP_SQRT_EXP, OP_RSQ_EXP: res_next = exp_res;
            default:                              res_next = '0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [WORD_W-1:0] res_q;
            always_ff @(posedge clk) begin
                if (rst) res_q <= '0;
                else res_q <= res_next;
            end
            assign result = res_q;
        end else begin : g_comb
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign result = res_next;
        end
    endgenerate
endmodule

// File: rtl/fpd_unit_chk.sv
module fpd_unit_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_sel,
    input logic [31:0] operand,
    input logic [31:0] result
);
    logic [2:0]  obs_op;
    logic [31:0] obs_opd;
    logic        obs_ok;
    logic        special;
    logic        normal;

    generate
        if (OUT_REG) begin : g_dly
            always_ff @(posedge clk) begin
                obs_ok  <= !rst;
                obs_op  <= op_sel;
                obs_opd <= operand;
            end
        end else begin : g_live
            assign obs_ok  = 1'b1;
            assign obs_op  = op_sel;
            assign obs_opd = operand;
        end
    endgenerate

    assign special = (obs_opd[30:23] == 8'hFF) || (obs_opd[30:0] == 31'd0);
    assign normal  = (obs_opd[30:23] != 8'h00) && (obs_opd[30:23] != 8'hFF);

    a_r1_rcp_mant_window: assert property (@(posedge clk) disable iff (rst)
        (obs_ok && obs_op == 3'd0 && !special) |-> (result[30:23] == 8'd126 && result[31] == obs_opd[31]));

    // R2: for a normal operand, field parity decides 125 versus 126
    a_r2_sqrt_mant_parity: assert property (@(posedge clk) disable iff (rst)
        (obs_ok && obs_op == 3'd1 && normal) |->
        ((result[30:23] == 8'd125 || result[30:23] == 8'd126) && result[23] == obs_opd[23] && result[31] == obs_opd[31]));

    a_r3_rcp_exp_normal: assert property (@(posedge clk) disable iff (rst)
        (obs_ok && obs_op == 3'd2 && normal) |-> ($signed(result) == 32'sd126 - $signed({24'd0, obs_opd[30:23]})));

    a_r7_special_passthru: assert property (@(posedge clk) disable iff (rst)
        (obs_ok && obs_op <= 3'd1 && special) |-> (result == obs_opd));

    a_r8_special_exp_zero: assert property (@(posedge clk) disable iff (rst)
        (obs_ok && obs_op >= 3'd2 && obs_op <= 3'd4 && special) |-> (result == 32'd0));

    a_r9_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (obs_ok && obs_op >= 3'd5) |-> (result == 32'd0));
endmodule

bind fpd_unit fpd_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst(rst), .op_sel(op_sel), .operand(operand), .result(result)
);

// File: tb/fpd_unit_test.sv
module fpd_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = 3'd0;
    logic [31:0] operand = 32'd0;
    logic [31:0] res_c;
    logic [31:0] res_r;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpd_unit #(.OUT_REG(1'b0)) uut   (.clk(clk), .rst(rst), .op_sel(op_sel), .operand(operand), .result(res_c));
    fpd_unit #(.OUT_REG(1'b1)) uut_q (.clk(clk), .rst(rst), .op_sel(op_sel), .operand(operand), .result(res_r));

    // {requirement number, op code, operand, expected}
    localparam int NV = 57;
    localparam logic [74:0] VEC [0:NV-1] = '{
        // 1.0 : e = 0 (R1 R2 R3 R4 R5)
        {8'd1, 3'd0, 32'h3F800000, 32'h3F000000},
        {8'd2, 3'd1, 32'h3F800000, 32'h3E800000},
        {8'd3, 3'd2, 32'h3F800000, 32'hFFFFFFFF},
        {8'd4, 3'd3, 32'h3F800000, 32'h00000001},
        {8'd5, 3'd4, 32'h3F800000, 32'hFFFFFFFF},
        // 2.0 : e = 1
        {8'd2, 3'd1, 32'h40000000, 32'h3F000000},
        {8'd3, 3'd2, 32'h40000000, 32'hFFFFFFFE},
        {8'd4, 3'd3, 32'h40000000, 32'h00000001},
        {8'd5, 3'd4, 32'h40000000, 32'hFFFFFFFF},
        // -3.0 : sign kept
        {8'd1, 3'd0, 32'hC0400000, 32'hBF400000},
        {8'd2, 3'd1, 32'hC0400000, 32'hBF400000},
        // 0.1875 : e = -3, floor toward negative infinity
        {8'd2, 3'd1, 32'h3E400000, 32'h3F400000},
        {8'd3, 3'd2, 32'h3E400000, 32'h00000002},
        {8'd4, 3'd3, 32'h3E400000, 32'hFFFFFFFF},
        {8'd5, 3'd4, 32'h3E400000, 32'h00000001},
        // 1024.0 : e = 10
        {8'd2, 3'd1, 32'h44800000, 32'h3E800000},
        {8'd3, 3'd2, 32'h44800000, 32'hFFFFFFF5},
        {8'd4, 3'd3, 32'h44800000, 32'h00000006},
        {8'd5, 3'd4, 32'h44800000, 32'hFFFFFFFA},
        // largest normal : e = 127
        {8'd1, 3'd0, 32'h7F7FFFFF, 32'h3F7FFFFF},
        {8'd2, 3'd1, 32'h7F7FFFFF, 32'h3F7FFFFF},
        {8'd3, 3'd2, 32'h7F7FFFFF, 32'hFFFFFF80},
        {8'd4, 3'd3, 32'h7F7FFFFF, 32'h00000040},
        {8'd5, 3'd4, 32'h7F7FFFFF, 32'hFFFFFFC0},
        // smallest normal : e = -126
        {8'd1, 3'd0, 32'h00800000, 32'h3F000000},
        {8'd2, 3'd1, 32'h00800000, 32'h3E800000},
        {8'd3, 3'd2, 32'h00800000, 32'h0000007D},
        {8'd4, 3'd3, 32'h00800000, 32'hFFFFFFC2},
        {8'd5, 3'd4, 32'h00800000, 32'h0000003E},
        // smallest denormal : e = -149 (R6)
        {8'd6, 3'd0, 32'h00000001, 32'h3F000000},
        {8'd6, 3'd1, 32'h00000001, 32'h3F000000},
        {8'd6, 3'd2, 32'h00000001, 32'h00000094},
        {8'd6, 3'd3, 32'h00000001, 32'hFFFFFFB6},
        {8'd6, 3'd4, 32'h00000001, 32'h0000004A},
        // denormal, no leading zero : e = -127, m = 1.5 (R6)
        {8'd6, 3'd0, 32'h00600000, 32'h3F400000},
        {8'd6, 3'd1, 32'h00600000, 32'h3F400000},
        {8'd6, 3'd2, 32'h00600000, 32'h0000007E},
        {8'd6, 3'd3, 32'h00600000, 32'hFFFFFFC1},
        {8'd6, 3'd4, 32'h00600000, 32'h0000003F},
        // negative denormal : e = -128, m = 1.5 (R6)
        {8'd6, 3'd0, 32'h80300000, 32'hBF400000},
        {8'd6, 3'd1, 32'h80300000, 32'hBEC00000},
        {8'd6, 3'd2, 32'h80300000, 32'h0000007F},
        {8'd6, 3'd3, 32'h80300000, 32'hFFFFFFC1},
        {8'd6, 3'd4, 32'h80300000, 32'h0000003F},
        // specials on mantissa ops (R7)
        {8'd7, 3'd0, 32'h00000000, 32'h00000000},
        {8'd7, 3'd1, 32'h80000000, 32'h80000000},
        {8'd7, 3'd0, 32'h7F800000, 32'h7F800000},
        {8'd7, 3'd1, 32'hFF800000, 32'hFF800000},
        {8'd7, 3'd1, 32'h7FC00001, 32'h7FC00001},
        // specials on exponent ops (R8)
        {8'd8, 3'd2, 32'h7F800000, 32'h00000000},
        {8'd8, 3'd3, 32'h00000000, 32'h00000000},
        {8'd8, 3'd4, 32'h7FC00001, 32'h00000000},
        {8'd8, 3'd2, 32'h80000000, 32'h00000000},
        // undefined codes (R9)
        {8'd9, 3'd5, 32'h3F800000, 32'h00000000},
        {8'd9, 3'd6, 32'h3F800000, 32'h00000000},
        {8'd9, 3'd7, 32'h3F800000, 32'h00000000},
        {8'd9, 3'd7, 32'h00000001, 32'h00000000}
    };

    task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state: register clear, unclocked path unaffected (R10)
        @(negedge clk);
        op_sel  = 3'd2;
        operand = 32'h3F800000;
        repeat (2) @(posedge clk);
        #2;
        chk("registered output held at zero in reset", 10, res_r, 32'h0);
        chk("unclocked output ignores reset", 3, res_c, 32'hFFFFFFFF);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sel  = VEC[i][66:64];
            operand = VEC[i][63:32];
            #2;
            chk($sformatf("vec %0d unclocked", i), int'(VEC[i][74:67]), res_c, VEC[i][31:0]);
            @(posedge clk);
            #2;
            chk($sformatf("vec %0d registered", i), int'(VEC[i][74:67]), res_r, VEC[i][31:0]);
        end

        // R10: latency of one edge on the registered copy
        @(negedge clk);
        op_sel  = 3'd4;
        operand = 32'h44800000;
        #2;
        chk("registered output before edge keeps old value", 10, res_r, 32'h0);
        @(posedge clk);
        #2;
        chk("registered output after edge", 10, res_r, 32'hFFFFFFFA);

        // R10: reset in mid-run clears the register only
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("mid-run reset clears register", 10, res_r, 32'h0);
        chk("mid-run reset leaves unclocked path live", 5, res_c, 32'hFFFFFFFA);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk("register reloads after reset", 10, res_r, 32'hFFFFFFFA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule